// File: doc/BRIEF.md
# Wakeup-Driven Issue Queue

This block is a small associative scheduler that sits between rename/dispatch and a single functional unit. Each slot keeps a waiting instruction's opcode, destination tag, two source tags, a ready flag for each source and the age stamp it was dispatched with. Every cycle, up to two completed-result tags are broadcast into the queue. Each broadcast tag is compared against every pending source tag, and a match marks that source as ready.

A slot whose two sources are both ready may issue. When several slots are ready, the one dispatched earliest wins, whatever slot index it happens to occupy. One instruction leaves per cycle on the issue port. A flush carrying an age boundary discards every waiting instruction younger than that boundary. The queue raises a full flag when no slot is free, and a dispatch offered while full is dropped.

Top module: `wakeup_issue_queue`

## Requirements
- R1: While `rst` is high at a clock edge, every slot is emptied, so after reset `full` and `issueValid` are 0.
- R2: A dispatch (`dispValid`=1 while `full`=0, not dropped by R8) takes a free slot at the clock edge. If both of its ready flags are 1, `issueValid` is 1 right after that edge, with `issueOp` and `issueDst` equal to the dispatched values.
- R3: A wake port `k` with `wakeValid[k]`=1 carries its tag on `wakeTags[k*TAG_W +: TAG_W]`. At the clock edge it sets the ready flag of every waiting source whose tag equals it. A port with `wakeValid[k]`=0 sets nothing. A slot is eligible only when both of its sources are ready.
- R4: A broadcast in the same cycle as a dispatch also matches the incoming instruction's source tags.
- R5: Among eligible slots, the one dispatched earliest is issued, independent of slot index. At most one is issued per cycle.
- R6: The issued slot is freed at the clock edge that ends its issue cycle, so each instruction appears on the issue port exactly once.
- R7: `full` is 1 exactly when all `IQ_DEPTH` slots (8) hold instructions. A dispatch offered while `full`=1 is ignored.
- R8: With `flushValid`=1, at the edge every slot whose age is younger than `flushAge` is discarded. Age `a` is younger when `(a - flushAge) mod 2^AGE_W` is nonzero and has its top bit clear. Equal or older slots stay. A dispatch in the same cycle that is younger than `flushAge` is dropped.
- R9: During a flush cycle, slots that the flush discards are excluded from selection in that same cycle: the issue outputs react combinationally to `flushValid`/`flushAge`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dispValid | input | 1 | Dispatch request |
| dispOp | input | OP_W | Opcode of dispatched instruction |
| dispDst | input | TAG_W | Destination tag |
| dispSrcA | input | TAG_W | First source tag |
| dispRdyA | input | 1 | First source already ready |
| dispSrcB | input | TAG_W | Second source tag |
| dispRdyB | input | 1 | Second source already ready |
| dispAge | input | AGE_W | Age stamp of the instruction |
| wakeValid | input | WAKE_PORTS | Per-port broadcast valid |
| wakeTags | input | WAKE_PORTS*TAG_W | Broadcast result tags, port k at bits k*TAG_W |
| flushValid | input | 1 | Flush request |
| flushAge | input | AGE_W | Flush age boundary |
| full | output | 1 | No free slot |
| issueValid | output | 1 | An instruction is issued this cycle |
| issueOp | output | OP_W | Opcode of issued instruction |
| issueDst | output | TAG_W | Destination tag of issued instruction |

## Verification
The age-order and flush properties assume that dispatch stamps are handed out in increasing order (modulo 2^AGE_W), and that the instructions in flight span less than half the age range. The stimulus assigns stamps in rising sequence and includes one wrap across zero. The properties also assume at most one dispatch per cycle with stable inputs at the edge. The bench drives everything one time unit after the rising edge, so this holds. Broadcast tags are chosen per scenario so that no stale slot could be matched by accident.

// File: rtl/wiq_pkg.sv
package wiq_pkg;
  parameter int IQ_DEPTH   = 8;
  parameter int WAKE_PORTS = 2;

  typedef struct packed {
    logic [IQ_DEPTH-1:0] allocOH;  // slot written by this cycle's dispatch
    logic [IQ_DEPTH-1:0] issueOH;  // slot selected for issue this cycle
  } iqStrobes_t;
endpackage

// File: rtl/wiq_datapath.sv
module wiq_datapath
  import wiq_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int OP_W  = 4,
  parameter int AGE_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  iqStrobes_t                 strobes,
  input  logic [OP_W-1:0]            dispOp,
  input  logic [TAG_W-1:0]           dispDst,
  input  logic [TAG_W-1:0]           dispSrcA,
  input  logic                       dispRdyA,
  input  logic [TAG_W-1:0]           dispSrcB,
  input  logic                       dispRdyB,
  input  logic [AGE_W-1:0]           dispAge,
  input  logic [WAKE_PORTS-1:0]      wakeValid,
  input  logic [WAKE_PORTS*TAG_W-1:0] wakeTags,
  input  logic [AGE_W-1:0]           flushAge,
  output logic [IQ_DEPTH-1:0]        entryRdy,
  output logic [IQ_DEPTH-1:0]        entryYounger,
  output logic                       dispYounger,
  output logic [OP_W-1:0]            issueOp,
  output logic [TAG_W-1:0]           issueDst
);

  // Any valid broadcast port carrying this tag
  function automatic logic tagHit(input logic [TAG_W-1:0] tag);
    logic hit;
    hit = 1'b0;
    for (int p = 0; p < WAKE_PORTS; p++) begin
      if (wakeValid[p] && (wakeTags[p*TAG_W +: TAG_W] == tag)) hit = 1'b1;
    end
    return hit;
  endfunction

  // Wrap-aware "strictly younger than the flush boundary"
  function automatic logic isYounger(input logic [AGE_W-1:0] age);
    logic [AGE_W-1:0] delta;
    delta = age - flushAge;
    return (delta != '0) && !delta[AGE_W-1];
  endfunction

  logic [IQ_DEPTH-1:0][OP_W-1:0]  opMasked;
  logic [IQ_DEPTH-1:0][TAG_W-1:0] dstMasked;

  assign dispYounger = isYounger(dispAge);

  for (genvar e = 0; e < IQ_DEPTH; e++) begin : g_slot
    logic [OP_W-1:0]  opQ;
    logic [TAG_W-1:0] dstQ;
    logic [TAG_W-1:0] srcAQ;
    logic [TAG_W-1:0] srcBQ;
    logic             rdyAQ;
    logic             rdyBQ;
    logic [AGE_W-1:0] ageQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        opQ   <= '0;
        dstQ  <= '0;
        srcAQ <= '0;
        srcBQ <= '0;
        rdyAQ <= 1'b0;
        rdyBQ <= 1'b0;
        ageQ  <= '0;
      end else if (strobes.allocOH[e]) begin
        opQ   <= dispOp;
        dstQ  <= dispDst;
        srcAQ <= dispSrcA;
        srcBQ <= dispSrcB;
        rdyAQ <= dispRdyA | tagHit(dispSrcA);
        rdyBQ <= dispRdyB | tagHit(dispSrcB);
        ageQ  <= dispAge;
      end else begin
        rdyAQ <= rdyAQ | tagHit(srcAQ);
        rdyBQ <= rdyBQ | tagHit(srcBQ);
      end
    end

    assign entryRdy[e]     = rdyAQ & rdyBQ;
    assign entryYounger[e] = isYounger(ageQ);
    assign opMasked[e]     = strobes.issueOH[e] ? opQ  : '0;
    assign dstMasked[e]    = strobes.issueOH[e] ? dstQ : '0;
  end

  // AND-OR read mux driven by the one-hot grant
  always_comb begin
    issueOp  = '0;
    issueDst = '0;
    for (int e = 0; e < IQ_DEPTH; e++) begin
      issueOp  = issueOp  | opMasked[e];
      issueDst = issueDst | dstMasked[e];
    end
  end

endmodule

// File: rtl/wiq_control.sv
module wiq_control
  import wiq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                dispValid,
  input  logic                flushValid,
  input  logic [IQ_DEPTH-1:0] entryRdy,
  input  logic [IQ_DEPTH-1:0] entryYounger,
  input  logic                dispYounger,
  output iqStrobes_t          strobes,
  output logic                full,
  output logic                issueValid,
  output logic [IQ_DEPTH-1:0] validVec
);

  logic [IQ_DEPTH-1:0]               validQ;
  logic [IQ_DEPTH-1:0][IQ_DEPTH-1:0] olderQ;   // olderQ[i][j]: slot i older than slot j
  logic [IQ_DEPTH-1:0]               killVec;
  logic [IQ_DEPTH-1:0]               candVec;
  logic [IQ_DEPTH-1:0]               grantVec;
  logic [IQ_DEPTH-1:0]               allocVec;
  logic                              acceptDisp;

  assign full       = &validQ;
  assign validVec   = validQ;
  assign killVec    = flushValid ? (validQ & entryYounger) : '0;
  assign candVec    = validQ & ~killVec & entryRdy;
  assign acceptDisp = dispValid && !full && !(flushValid && dispYounger);

  // Oldest-ready select: a candidate wins if no older candidate exists
  always_comb begin
    for (int i = 0; i < IQ_DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < IQ_DEPTH; j++) begin
        if (candVec[j] && olderQ[j][i]) blocked = 1'b1;
      end
      grantVec[i] = candVec[i] && !blocked;
    end
  end

  // Lowest free slot receives the dispatch
  always_comb begin
    logic found;
    found    = 1'b0;
    allocVec = '0;
    for (int i = 0; i < IQ_DEPTH; i++) begin
      if (acceptDisp && !validQ[i] && !found) begin
        allocVec[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign issueValid      = |grantVec;
  assign strobes.allocOH = allocVec;
  assign strobes.issueOH = grantVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      olderQ <= '0;
    end else begin
      validQ <= (validQ & ~killVec & ~grantVec) | allocVec;
      for (int i = 0; i < IQ_DEPTH; i++) begin
        for (int j = 0; j < IQ_DEPTH; j++) begin
          if (allocVec[i])      olderQ[i][j] <= 1'b0;
          else if (allocVec[j]) olderQ[i][j] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wakeup_issue_queue.sv
module wakeup_issue_queue
  import wiq_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int OP_W  = 4,
  parameter int AGE_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        dispValid,
  input  logic [OP_W-1:0]             dispOp,
  input  logic [TAG_W-1:0]            dispDst,
  input  logic [TAG_W-1:0]            dispSrcA,
  input  logic                        dispRdyA,
  input  logic [TAG_W-1:0]            dispSrcB,
  input  logic                        dispRdyB,
  input  logic [AGE_W-1:0]            dispAge,
  input  logic [WAKE_PORTS-1:0]       wakeValid,
  input  logic [WAKE_PORTS*TAG_W-1:0] wakeTags,
  input  logic                        flushValid,
  input  logic [AGE_W-1:0]            flushAge,
  output logic                        full,
  output logic                        issueValid,
  output logic [OP_W-1:0]             issueOp,
  output logic [TAG_W-1:0]            issueDst
);

  iqStrobes_t          strobes;
  logic [IQ_DEPTH-1:0] entryRdy;
  logic [IQ_DEPTH-1:0] entryYounger;
  logic                dispYounger;
  logic [IQ_DEPTH-1:0] validVec;
  logic [IQ_DEPTH-1:0] issueVec;

  assign issueVec = strobes.issueOH;

  wiq_control u_control (
    .clk          (clk),
    .rst          (rst),
    .dispValid    (dispValid),
    .flushValid   (flushValid),
    .entryRdy     (entryRdy),
    .entryYounger (entryYounger),
    .dispYounger  (dispYounger),
    .strobes      (strobes),
    .full         (full),
    .issueValid   (issueValid),
    .validVec     (validVec)
  );

  wiq_datapath #(
    .TAG_W (TAG_W),
    .OP_W  (OP_W),
    .AGE_W (AGE_W)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .dispOp       (dispOp),
    .dispDst      (dispDst),
    .dispSrcA     (dispSrcA),
    .dispRdyA     (dispRdyA),
    .dispSrcB     (dispSrcB),
    .dispRdyB     (dispRdyB),
    .dispAge      (dispAge),
    .wakeValid    (wakeValid),
    .wakeTags     (wakeTags),
    .flushAge     (flushAge),
    .entryRdy     (entryRdy),
    .entryYounger (entryYounger),
    .dispYounger  (dispYounger),
    .issueOp      (issueOp),
    .issueDst     (issueDst)
  );

endmodule

// File: rtl/wiq_checker.sv
module wiq_checker
  import wiq_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                dispValid,
  input logic                flushValid,
  input logic                full,
  input logic                issueValid,
  input logic [IQ_DEPTH-1:0] validVec,
  input logic [IQ_DEPTH-1:0] issueVec
);

  // R1: a reset edge leaves no slot occupied
  a_r1_reset_empties: assert property (@(posedge clk) rst |=> (validVec == '0));

  // R5: at most one grant per cycle
  a_r5_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issueVec));

  // R5: the grant only points at an occupied slot
  a_r5_grant_occupied: assert property (@(posedge clk) disable iff (rst)
    (issueVec & ~validVec) == '0);

  // R6: the issued slot is empty after the edge
  a_r6_issued_leaves: assert property (@(posedge clk) disable iff (rst)
    issueValid |=> ((validVec & $past(issueVec)) == '0));

  // R7: occupancy cannot grow while full
  a_r7_no_growth_full: assert property (@(posedge clk) disable iff (rst)
    full |=> ($countones(validVec) <= $past($countones(validVec))));

  // R2: an accepted dispatch never lowers occupancy
  a_r2_dispatch_kept: assert property (@(posedge clk) disable iff (rst)
    (dispValid && !full && !flushValid) |=>
      ($countones(validVec) >= $past($countones(validVec))));

endmodule

bind wakeup_issue_queue wiq_checker u_wiq_checker (
  .clk        (clk),
  .rst        (rst),
  .dispValid  (dispValid),
  .flushValid (flushValid),
  .full       (full),
  .issueValid (issueValid),
  .validVec   (validVec),
  .issueVec   (issueVec)
);

// File: tb/wakeup_issue_queue_bench.sv
module wakeup_issue_queue_bench;
  localparam int TAG_W = 6;
  localparam int OP_W  = 4;
  localparam int AGE_W = 5;
  localparam int WP    = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             dispValid;
  logic [OP_W-1:0]  dispOp;
  logic [TAG_W-1:0] dispDst, dispSrcA, dispSrcB;
  logic             dispRdyA, dispRdyB;
  logic [AGE_W-1:0] dispAge;
  logic [WP-1:0]    wakeValid;
  logic [WP*TAG_W-1:0] wakeTags;
  logic             flushValid;
  logic [AGE_W-1:0] flushAge;
  logic             full, issueValid;
  logic [OP_W-1:0]  issueOp;
  logic [TAG_W-1:0] issueDst;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  wakeup_issue_queue #(.TAG_W(TAG_W), .OP_W(OP_W), .AGE_W(AGE_W)) u_wakeup_issue_queue (
    .clk(clk), .rst(rst), .dispValid(dispValid), .dispOp(dispOp), .dispDst(dispDst),
    .dispSrcA(dispSrcA), .dispRdyA(dispRdyA), .dispSrcB(dispSrcB), .dispRdyB(dispRdyB),
    .dispAge(dispAge), .wakeValid(wakeValid), .wakeTags(wakeTags),
    .flushValid(flushValid), .flushAge(flushAge), .full(full),
    .issueValid(issueValid), .issueOp(issueOp), .issueDst(issueDst)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearInputs();
    dispValid = 0; dispOp = '0; dispDst = '0; dispSrcA = '0; dispSrcB = '0;
    dispRdyA = 0; dispRdyB = 0; dispAge = '0;
    wakeValid = '0; wakeTags = '0; flushValid = 0; flushAge = '0;
  endtask

  task automatic setDisp(input int op, input int dst, input int sa, input logic ra,
                         input int sb, input logic rb, input int age);
    dispValid = 1; dispOp = OP_W'(op); dispDst = TAG_W'(dst);
    dispSrcA = TAG_W'(sa); dispRdyA = ra; dispSrcB = TAG_W'(sb); dispRdyB = rb;
    dispAge = AGE_W'(age);
  endtask

  task automatic setWake(input int port, input int tag);
    wakeValid[port] = 1'b1;
    wakeTags[port*TAG_W +: TAG_W] = TAG_W'(tag);
  endtask

  task automatic expectIssue(input string req, input int op, input int dst);
    chk(issueValid === 1'b1, req, "issueValid", int'(issueValid), 1);
    chk(issueOp == OP_W'(op), req, "issueOp", int'(issueOp), op);
    if (dst >= 0) chk(issueDst == TAG_W'(dst), req, "issueDst", int'(issueDst), dst);
  endtask

  task automatic expectIdle(input string req);
    chk(issueValid === 1'b0, req, "issueValid", int'(issueValid), 0);
  endtask

  task automatic t_reset();
    clearInputs();
    rst = 1;
    repeat (3) step();
    rst = 0;
    step();
    chk(full === 1'b0, "R1", "full after reset", int'(full), 0);
    expectIdle("R1");
  endtask

  task automatic t_basic();
    setDisp(3, 7, 1, 1, 2, 1, 1);
    step();
    clearInputs();
    expectIssue("R2", 3, 7);
    step();
    expectIdle("R6");
  endtask

  task automatic t_wake();
    setDisp(4, 8, 5, 0, 6, 1, 2);
    step();
    clearInputs();
    expectIdle("R3 pending source");
    setWake(1, 9);
    step();
    clearInputs();
    expectIdle("R3 mismatched tag");
    wakeValid = '0; wakeTags[0 +: TAG_W] = 6'd5;  // matching tag but port not valid
    step();
    clearInputs();
    expectIdle("R3 invalid port");
    setWake(1, 5);
    step();
    clearInputs();
    expectIssue("R3 port1", 4, 8);
    step();
    setDisp(5, 9, 12, 0, 13, 0, 3);
    step();
    clearInputs();
    setWake(0, 12);
    step();
    clearInputs();
    expectIdle("R3 one of two");
    setWake(0, 13);
    step();
    clearInputs();
    expectIssue("R3 port0", 5, 9);
    step();
    setDisp(6, 10, 14, 0, 15, 0, 4);
    step();
    clearInputs();
    setWake(0, 14);
    setWake(1, 15);
    step();
    clearInputs();
    expectIssue("R3 both ports", 6, 10);
    step();
    expectIdle("R6");
  endtask

  task automatic t_sameCycle();
    setDisp(2, 11, 20, 0, 21, 0, 5);
    setWake(0, 20);
    setWake(1, 21);
    step();
    clearInputs();
    expectIssue("R4", 2, 11);
    step();
  endtask

  task automatic t_oldest();
    setDisp(1, 1, 22, 0, 0, 1, 6);     // slot 0
    step();
    setDisp(2, 2, 23, 0, 0, 1, 7);     // slot 1
    step();
    clearInputs();
    setWake(0, 22);
    step();
    clearInputs();
    expectIssue("R5 first", 1, 1);
    step();                            // slot 0 freed here
    expectIdle("R6");
    setDisp(5, 3, 23, 0, 0, 1, 8);     // reuses slot 0, youngest
    step();
    clearInputs();
    setWake(1, 23);
    step();
    clearInputs();
    expectIssue("R5 older in higher slot", 2, 2);
    step();
    expectIssue("R5 younger in lower slot", 5, 3);
    step();
    expectIdle("R6");
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++) begin
      setDisp(6, k, 30, 0, 0, 1, 9 + k);
      step();
    end
    clearInputs();
    chk(full === 1'b1, "R7", "full with 8 slots", int'(full), 1);
    setDisp(9, 40, 0, 1, 0, 1, 17);    // would issue at once if accepted
    step();
    clearInputs();
    expectIdle("R7 dispatch while full");
    chk(full === 1'b1, "R7", "still full", int'(full), 1);
    setWake(0, 30);
    step();
    clearInputs();
    for (int k = 0; k < 8; k++) begin
      expectIssue("R5 drain order", 6, k);
      if (k == 1) chk(full === 1'b0, "R7", "full after one issue", int'(full), 0);
      step();
    end
    expectIdle("R7 extra dispatch absent");
    chk(full === 1'b0, "R7", "full after drain", int'(full), 0);
  endtask

  task automatic t_flush();
    setDisp(10, 1, 41, 0, 0, 1, 30); step();
    setDisp(11, 2, 41, 0, 0, 1, 31); step();
    setDisp(12, 3, 41, 0, 0, 1, 0);  step();
    setDisp(13, 4, 41, 0, 0, 1, 1);  step();
    clearInputs();
    flushValid = 1; flushAge = 5'd31;
    setDisp(14, 5, 0, 1, 0, 1, 2);     // younger than boundary: dropped
    step();
    clearInputs();
    expectIdle("R8 younger dispatch dropped");
    setWake(0, 41);
    step();
    clearInputs();
    expectIssue("R8 kept age 30", 10, 1);
    step();
    expectIssue("R8 kept boundary age", 11, 2);
    step();
    expectIdle("R8 wrapped ages discarded");
  endtask

  task automatic t_flushIssue();
    setDisp(7, 6, 0, 1, 0, 1, 8);
    step();
    clearInputs();
    expectIssue("R2", 7, 6);
    flushValid = 1; flushAge = 5'd7;
    #1;
    expectIdle("R9 same-cycle kill");
    step();
    clearInputs();
    expectIdle("R8 slot discarded");
    setDisp(8, 7, 0, 1, 0, 1, 9);
    step();
    clearInputs();
    flushValid = 1; flushAge = 5'd9;
    #1;
    expectIssue("R9 equal age survives", 8, 7);
    step();
    clearInputs();
    expectIdle("R6");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_wake();
    t_sameCycle();
    t_oldest();
    t_full();
    t_flush();
    t_flushIssue();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule